// File: doc/BRIEF.md
# Bus Grant and Power-Save Arbiter

This block decides, cycle by cycle, who owns the processor's external buses. It weighs three things: an external controller asking for the bus, a request to drop the processor into a low-power wait, and the core's own sequencing of machine cycles and instructions. The core tells the block when a machine cycle is in its final T state and when that state also closes an instruction. The block answers with a bus acknowledge, a per-lane output enable for the address, data and control pads, and a hold that stalls the core. It also drives inhibits that stop interrupt acknowledge and DRAM refresh, and a refresh strobe that is held high while another master owns the bus.

A bus request is taken only at the end of a machine cycle. It wins over any interrupt that falls due at the same boundary, and over a power-save request that arrives with it. Once the external master lets go, the block goes into power-save only if that request is still present and the grant began at an instruction boundary. A falling edge on the non-maskable interrupt pin is captured in a sticky flag, so an edge that arrives while the bus is lent out is not lost. While the bus is granted, the status code shown to the outside stays at the machine-cycle type that was in progress when the grant was taken.

Top module: `bus_grant_arbiter`

## Requirements
- R1: After reset, back_n is 1, every bus_oe bit is 1, core_hold, psave_active and nmi_pend are 0, and rfsh_n follows rfsh_core_n.
- R2: The grant is taken at a rising clock edge where breq_n is 0 and mc_last_t is 1. From that edge on, back_n is 0, all bus_oe bits are 0 and core_hold is 1. A low breq_n at an edge with mc_last_t at 0 changes nothing.
- R3: While back_n is 0, rfsh_n is 1 whatever rfsh_core_n does, and both int_inhibit and rfsh_inhibit are 1.
- R4: In any cycle where mc_last_t is 1 and breq_n is 0 before the grant, int_inhibit and rfsh_inhibit are already 1 in that same cycle, so the bus outranks an interrupt that falls due at that boundary.
- R5: The first rising edge at which the block is granted and sees breq_n at 1 ends the grant. From that edge on, back_n is 1 and all bus_oe bits are 1.
- R6: A 1-to-0 transition of nmi_n, sampled at the clock, sets nmi_pend, also while the bus is granted. nmi_pend stays 1 until an edge with nmi_clr at 1 and no new falling edge.
- R7: If breq_n is 0 and psave_req is 1 at an edge with both mc_last_t and instr_end at 1, the bus is granted first. When the grant ends, psave_active becomes 1 if psave_req is still 1 at that edge, and otherwise the block returns to normal running.
- R8: A grant taken at a machine-cycle end with instr_end at 0 never leads straight into power-save at release, even when psave_req is 1.
- R9: With breq_n at 1, an edge where psave_req, mc_last_t and instr_end are all 1 enters power-save: from that edge on, psave_active and core_hold are 1, and back_n and bus_oe stay at 1. psave_req at an edge with instr_end at 0 is ignored.
- R10: In power-save, the first edge where psave_req is 0 clears psave_active and core_hold. Bus requests are ignored while in power-save.
- R11: While back_n is 0, status_o holds the mc_type value sampled at the edge that took the grant. At all other times, status_o equals mc_type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| breq_n | input | 1 | External bus request, active low |
| psave_req | input | 1 | Power-save request, active high |
| mc_last_t | input | 1 | Core is in the final T state of a machine cycle |
| instr_end | input | 1 | That final T state also closes an instruction |
| mc_type | input | ST_W | Machine-cycle status code from the core |
| rfsh_core_n | input | 1 | Refresh strobe from the core, active low |
| nmi_n | input | 1 | Non-maskable interrupt pin, falling-edge sensitive |
| nmi_clr | input | 1 | Interrupt logic has taken the latched NMI |
| back_n | output | 1 | Bus acknowledge, active low |
| bus_oe | output | OE_W | Pad output enable per bus lane, 1 = drive |
| status_o | output | ST_W | Status code shown outside, held during grant |
| rfsh_n | output | 1 | Refresh strobe to the pads |
| int_inhibit | output | 1 | Blocks interrupt and restart acknowledge |
| rfsh_inhibit | output | 1 | Blocks DRAM refresh cycles |
| core_hold | output | 1 | Stalls the core sequencer |
| psave_active | output | 1 | Power-save mode in force |
| nmi_pend | output | 1 | Latched NMI for the interrupt logic |

## Verification
The bench holds a bus request low across cycles where mc_last_t is 0. A design that sampled the request at every edge would grant mid-cycle and corrupt a transfer in flight. It raises the request together with a due interrupt and checks that the inhibit is already up in that same cycle. If it were not, an interrupt acknowledge would slip in ahead of the external master. The power-save cases run in both orders. In one, the request is withdrawn before the bus comes back, and a design that latched it at acceptance would sleep anyway. In the other, the grant starts mid-instruction, and a design that slept on release would stop the core in the middle of an instruction. NMI edges are sent during a grant, and the status code is changed while granted, to catch a lost interrupt and a status output that drifts.

// File: rtl/bga_pkg.sv
package bga_pkg;
   typedef enum logic [1:0] {
      ARB_RUN   = 2'd0,
      ARB_GRANT = 2'd1,
      ARB_SAVE  = 2'd2
   } arb_state_t;
endpackage

// File: rtl/bga_nmi_latch.sv
// Sticky capture of a falling edge on the non-maskable interrupt pin.
module bga_nmi_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_n,
   input  logic nmi_clr,
   output logic nmi_pend
);
   logic nmi_q;
   logic fall;

   assign fall = nmi_q & ~nmi_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_q    <= 1'b1;
         nmi_pend <= 1'b0;
      end else begin
         nmi_q <= nmi_n;
         if (fall)
            nmi_pend <= 1'b1;   // a new edge wins over a same-cycle clear
         else if (nmi_clr)
            nmi_pend <= 1'b0;
      end
   end
endmodule

// File: rtl/bga_ctrl.sv
// Ownership sequencer: run, granted to external master, power-save.
module bga_ctrl
   import bga_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       breq_n,
   input  logic       psave_req,
   input  logic       mc_last_t,
   input  logic       instr_end,
   output arb_state_t state,
   output logic       capture,
   output logic       int_inhibit,
   output logic       rfsh_inhibit
);
   arb_state_t nxt;
   logic       at_boundary;
   logic       take_bus;
   logic       take_save;
   logic       granted;

   assign granted   = (state == ARB_GRANT);
   assign take_bus  = (state == ARB_RUN) & mc_last_t & ~breq_n;
   assign take_save = (state == ARB_RUN) & mc_last_t & instr_end & breq_n & psave_req;
   assign capture   = take_bus;

   // the request outranks anything due at the same boundary
   assign int_inhibit  = granted | take_bus;
   assign rfsh_inhibit = granted | take_bus;

   always_comb begin
      nxt = state;
      unique case (state)
         ARB_RUN: begin
            if (take_bus)
               nxt = ARB_GRANT;
            else if (take_save)
               nxt = ARB_SAVE;
         end
         ARB_GRANT: begin
            if (breq_n)
               nxt = (at_boundary && psave_req) ? ARB_SAVE : ARB_RUN;
         end
         ARB_SAVE: begin
            if (!psave_req)
               nxt = ARB_RUN;
         end
         default: nxt = ARB_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ARB_RUN;
         at_boundary <= 1'b0;
      end else begin
         state <= nxt;
         if (take_bus)
            at_boundary <= instr_end;
      end
   end
endmodule

// File: rtl/bga_bus_mux.sv
// Pad enables, held status code and forced refresh strobe.
module bga_bus_mux #(
   parameter int ST_W = 3,
   parameter int OE_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            capture,
   input  logic            granted,
   input  logic [ST_W-1:0] mc_type,
   input  logic            rfsh_core_n,
   output logic [ST_W-1:0] status_o,
   output logic            rfsh_n,
   output logic [OE_W-1:0] bus_oe
);
   logic [ST_W-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held <= '0;
      else if (capture)
         held <= mc_type;
   end

   assign status_o = granted ? held : mc_type;
   assign rfsh_n   = granted | rfsh_core_n;

   for (genvar g = 0; g < OE_W; g++) begin : g_lane
      assign bus_oe[g] = ~granted;
   end
endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter
   import bga_pkg::*;
#(
   parameter int ST_W = 3,
   parameter int OE_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            breq_n,
   input  logic            psave_req,
   input  logic            mc_last_t,
   input  logic            instr_end,
   input  logic [ST_W-1:0] mc_type,
   input  logic            rfsh_core_n,
   input  logic            nmi_n,
   input  logic            nmi_clr,
   output logic            back_n,
   output logic [OE_W-1:0] bus_oe,
   output logic [ST_W-1:0] status_o,
   output logic            rfsh_n,
   output logic            int_inhibit,
   output logic            rfsh_inhibit,
   output logic            core_hold,
   output logic            psave_active,
   output logic            nmi_pend
);
   if (ST_W < 1 || ST_W > 16) begin : g_bad_st
      $error("ST_W out of range");
   end
   if (OE_W < 1 || OE_W > 32) begin : g_bad_oe
      $error("OE_W out of range");
   end

   arb_state_t state;
   logic       capture;
   logic       granted;

   bga_ctrl i_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .breq_n       (breq_n),
      .psave_req    (psave_req),
      .mc_last_t    (mc_last_t),
      .instr_end    (instr_end),
      .state        (state),
      .capture      (capture),
      .int_inhibit  (int_inhibit),
      .rfsh_inhibit (rfsh_inhibit)
   );

   assign granted      = (state == ARB_GRANT);
   assign back_n       = ~granted;
   assign psave_active = (state == ARB_SAVE);
   assign core_hold    = (state != ARB_RUN);

   bga_bus_mux #(.ST_W(ST_W), .OE_W(OE_W)) i_mux (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture     (capture),
      .granted     (granted),
      .mc_type     (mc_type),
      .rfsh_core_n (rfsh_core_n),
      .status_o    (status_o),
      .rfsh_n      (rfsh_n),
      .bus_oe      (bus_oe)
   );

   bga_nmi_latch i_nmi (
      .clk      (clk),
      .rst_n    (rst_n),
      .nmi_n    (nmi_n),
      .nmi_clr  (nmi_clr),
      .nmi_pend (nmi_pend)
   );
endmodule

// File: rtl/bga_checker.sv
module bga_checker #(
   parameter int ST_W = 3,
   parameter int OE_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            breq_n,
   input logic            mc_last_t,
   input logic            nmi_clr,
   input logic            back_n,
   input logic [OE_W-1:0] bus_oe,
   input logic [ST_W-1:0] status_o,
   input logic            rfsh_n,
   input logic            int_inhibit,
   input logic            rfsh_inhibit,
   input logic            psave_active,
   input logic            nmi_pend
);
   a_r2_grant_at_cycle_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(back_n) |-> $past(mc_last_t && !breq_n));
   a_r2_pads_off: assert property (@(posedge clk) disable iff (!rst_n)
      !back_n |-> (bus_oe == '0));
   a_r3_refresh_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      !back_n |-> (rfsh_n && int_inhibit && rfsh_inhibit));
   a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!back_n && breq_n) |=> back_n);
   a_r6_nmi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_pend && !nmi_clr) |=> nmi_pend);
   a_r10_save_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
      psave_active |-> back_n);
   a_r11_status_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!back_n && $past(!back_n)) |-> $stable(status_o));
endmodule

bind bus_grant_arbiter bga_checker #(.ST_W(ST_W), .OE_W(OE_W)) i_bga_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .breq_n       (breq_n),
   .mc_last_t    (mc_last_t),
   .nmi_clr      (nmi_clr),
   .back_n       (back_n),
   .bus_oe       (bus_oe),
   .status_o     (status_o),
   .rfsh_n       (rfsh_n),
   .int_inhibit  (int_inhibit),
   .rfsh_inhibit (rfsh_inhibit),
   .psave_active (psave_active),
   .nmi_pend     (nmi_pend)
);

// File: tb/test_bus_grant_arbiter.sv
`timescale 1ns/1ps
module test_bus_grant_arbiter;
   localparam int ST_W = 3;
   localparam int OE_W = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            breq_n = 1'b1;
   logic            psave_req = 1'b0;
   logic            mc_last_t = 1'b0;
   logic            instr_end = 1'b0;
   logic [ST_W-1:0] mc_type = '0;
   logic            rfsh_core_n = 1'b1;
   logic            nmi_n = 1'b1;
   logic            nmi_clr = 1'b0;
   logic            back_n;
   logic [OE_W-1:0] bus_oe;
   logic [ST_W-1:0] status_o;
   logic            rfsh_n;
   logic            int_inhibit;
   logic            rfsh_inhibit;
   logic            core_hold;
   logic            psave_active;
   logic            nmi_pend;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   bus_grant_arbiter #(.ST_W(ST_W), .OE_W(OE_W)) i_bus_grant_arbiter (.*);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic idle();
      breq_n = 1'b1; psave_req = 1'b0; mc_last_t = 1'b0; instr_end = 1'b0;
      nmi_clr = 1'b0; rfsh_core_n = 1'b1;
      step();
   endtask

   task automatic t_reset();
      check(back_n == 1'b1, "R1 back_n", back_n, 1);
      check(bus_oe == '1, "R1 bus_oe", bus_oe, 7);
      check({core_hold, psave_active, nmi_pend} == 3'b000, "R1 hold/save/nmi",
            {core_hold, psave_active, nmi_pend}, 0);
      rfsh_core_n = 1'b0; #1;
      check(rfsh_n == 1'b0, "R1 rfsh follows", rfsh_n, 0);
      rfsh_core_n = 1'b1;
   endtask

   task automatic t_midcycle_ignored();
      breq_n = 1'b0; mc_last_t = 1'b0;
      step(); step();
      check(back_n == 1'b1, "R2 no grant mid-cycle", back_n, 1);
      check(bus_oe == '1, "R2 pads on mid-cycle", bus_oe, 7);
      idle();
   endtask

   task automatic t_grant_release();
      mc_type = 3'd5; breq_n = 1'b0; mc_last_t = 1'b1;
      step();
      mc_last_t = 1'b0; mc_type = 3'd2;
      check(back_n == 1'b0, "R2 grant", back_n, 0);
      check(bus_oe == '0, "R2 pads off", bus_oe, 0);
      check(core_hold == 1'b1, "R2 core hold", core_hold, 1);
      rfsh_core_n = 1'b0; #1;
      check(rfsh_n == 1'b1, "R3 rfsh high", rfsh_n, 1);
      check(int_inhibit && rfsh_inhibit, "R3 inhibits", {int_inhibit, rfsh_inhibit}, 3);
      check(status_o == 3'd5, "R11 status held", status_o, 5);
      step();
      check(back_n == 1'b0, "R5 grant kept while low", back_n, 0);
      breq_n = 1'b1;
      step();
      check(back_n == 1'b1, "R5 release", back_n, 1);
      check(bus_oe == '1, "R5 pads on", bus_oe, 7);
      check(status_o == 3'd2, "R11 status follows", status_o, 2);
      check(psave_active == 1'b0, "R7 no save without request", psave_active, 0);
      idle();
   endtask

   task automatic t_int_priority();
      mc_last_t = 1'b1; instr_end = 1'b1; breq_n = 1'b0; #1;
      check(int_inhibit == 1'b1, "R4 inhibit same cycle", int_inhibit, 1);
      check(rfsh_inhibit == 1'b1, "R4 refresh inhibit same cycle", rfsh_inhibit, 1);
      step();
      mc_last_t = 1'b0; instr_end = 1'b0;
      nmi_n = 1'b0; step(); nmi_n = 1'b1; step();
      check(nmi_pend == 1'b1, "R6 nmi latched in grant", nmi_pend, 1);
      breq_n = 1'b1; step();
      check(nmi_pend == 1'b1, "R6 nmi kept after release", nmi_pend, 1);
      nmi_clr = 1'b1; step(); nmi_clr = 1'b0;
      check(nmi_pend == 1'b0, "R6 nmi cleared", nmi_pend, 0);
      idle();
   endtask

   task automatic t_ps_with_breq(input bit keep);
      breq_n = 1'b0; psave_req = 1'b1; mc_last_t = 1'b1; instr_end = 1'b1;
      step();
      mc_last_t = 1'b0; instr_end = 1'b0;
      check(back_n == 1'b0 && psave_active == 1'b0, "R7 bus first",
            {back_n, psave_active}, 0);
      psave_req = keep;
      step();
      breq_n = 1'b1;
      step();
      check(psave_active == keep, "R7 save after release", psave_active, keep);
      check(back_n == 1'b1, "R7 bus released", back_n, 1);
      if (keep) begin
         breq_n = 1'b0; mc_last_t = 1'b1;
         step();
         check(back_n == 1'b1, "R10 request ignored in save", back_n, 1);
         check(bus_oe == '1, "R9 pads on in save", bus_oe, 7);
         breq_n = 1'b1; mc_last_t = 1'b0; psave_req = 1'b0;
         step();
         check(psave_active == 1'b0 && core_hold == 1'b0, "R10 wake",
               {psave_active, core_hold}, 0);
      end
      idle();
   endtask

   task automatic t_ps_nonboundary();
      breq_n = 1'b0; psave_req = 1'b1; mc_last_t = 1'b1; instr_end = 1'b0;
      step();
      mc_last_t = 1'b0; breq_n = 1'b1;
      step();
      check(psave_active == 1'b0, "R8 no save mid-instruction", psave_active, 0);
      check(core_hold == 1'b0, "R8 core runs", core_hold, 0);
      idle();
   endtask

   task automatic t_ps_alone();
      psave_req = 1'b1; mc_last_t = 1'b1; instr_end = 1'b0;
      step();
      check(psave_active == 1'b0, "R9 ignored mid-instruction", psave_active, 0);
      instr_end = 1'b1;
      step();
      mc_last_t = 1'b0; instr_end = 1'b0;
      check(psave_active && core_hold, "R9 enter save", {psave_active, core_hold}, 3);
      check(back_n == 1'b1, "R9 no grant in save", back_n, 1);
      step();
      check(psave_active == 1'b1, "R10 stays while requested", psave_active, 1);
      psave_req = 1'b0;
      step();
      check(psave_active == 1'b0, "R10 leave save", psave_active, 0);
      idle();
   endtask

   initial begin
      #1000000;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #22 rst_n = 1'b1;
      #1;
      t_reset();
      step();
      t_midcycle_ignored();
      t_grant_release();
      t_int_priority();
      t_ps_with_breq(1'b1);
      t_ps_with_breq(1'b0);
      t_ps_nonboundary();
      t_ps_alone();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule